// File: doc/BRIEF.md
# Flash Completion Poller

This block runs on the host side. Once a program or erase has been sent to a parallel NOR flash, the block takes over and works out whether that operation finished well, finished badly, or is still running. A one-cycle start pulse gives it three things: the address to poll, the data that was written, and the polling method to use. It then reads the device again and again over a request/response bus. It allows only one read in flight at a time.

There are three methods. The first compares the completion bit of each status word with the written data. The second looks for a toggle bit that stops changing between two back-to-back reads. The third waits for the device's ready/busy pin to go high. The device can raise an internal time-limit flag. When it does, the block takes one more look before it decides, because the completion indication can change in the same instant as that flag.

When the result is failure, the block writes the reset command to the polled address so the device goes back to read mode. Only then does it report. A poll budget sets an upper bound on how long the block can stay busy.

Top module: `flash_done_poller`

## Requirements
- R1: After reset, done_o, pass_o, fail_o, busy_o and bus_req_valid_o are all 0.
- R2: Mode 0 is data-bar polling. Each read is a bus read at the latched address. If bit 7 of the returned word equals bit 7 of the expected data, the operation passed, and no write is issued.
- R3: In mode 0, if bit 7 does not match and bit 5 (the time-limit flag) is 0, the block issues another read.
- R4: In mode 0, if bit 7 does not match and bit 5 is 1, the block issues exactly one more read. A bit 7 match on that read means pass; a mismatch means fail.
- R5: Mode 1 is toggle polling. Reads come in pairs. If bit 6 has the same value in both reads of a pair, the operation passed. If bit 6 differs and bit 5 of the second read is 0, the block starts a new pair.
- R6: In mode 1, if bit 6 differs and bit 5 of the second read is 1, the block makes two more reads. If bit 6 still differs between them the result is fail; otherwise it is pass.
- R7: Mode values 2 and 3 select the ready/busy pin. The block passes when rdy_busy_i is 1 and issues no read.
- R8: On fail, the block issues exactly one bus write with data F0h (zero-extended) to the latched address, and only then completes. done_o is a one-cycle pulse, and at that moment exactly one of pass_o and fail_o is 1. Both hold their value until the next accepted start.
- R9: An inconclusive check counts against a budget of MAX_POLLS. In modes 0 and 1 that is a check that leads to a new read or pair. In the pin mode it is one cycle with rdy_busy_i low. Reaching the budget ends the operation as fail (through R8).
- R10: A request stays asserted, with address, write flag and data unchanged, until bus_req_ready_i accepts it. A new read is issued only after the previous response has arrived.
- R11: A start pulse that arrives while busy_o is 1 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle start pulse |
| start_addr_i | input | AW | Address to poll |
| start_data_i | input | DW | Data that was programmed |
| start_mode_i | input | 2 | 0 data-bar, 1 toggle, 2/3 ready pin |
| rdy_busy_i | input | 1 | Device ready/busy pin, 1 = ready |
| bus_req_valid_o | output | 1 | Bus request valid |
| bus_req_ready_i | input | 1 | Bus request accepted |
| bus_req_write_o | output | 1 | 1 = write, 0 = read |
| bus_req_addr_o | output | AW | Request address |
| bus_req_wdata_o | output | DW | Write data |
| bus_rsp_valid_i | input | 1 | Read response valid |
| bus_rsp_data_i | input | DW | Read response data |
| done_o | output | 1 | Completion pulse |
| pass_o | output | 1 | Operation passed |
| fail_o | output | 1 | Operation failed |
| busy_o | output | 1 | Poll in progress |

## Verification
The assertions assume the bus never sends a response that was not asked for. Each read must get exactly one response, and it must arrive after the read is accepted. The bench's bus model meets this: it replies one cycle after each accepted read and never replies to a write. Some scenarios gate the ready signal on alternate cycles, so that the hold rule is exercised under stalls. The assertions also assume that start is a pulse. The bench drives it high for one cycle only, and sends its one extra pulse on purpose while a poll is in progress.

// File: rtl/fpoll_pkg.sv
package fpoll_pkg;
  typedef enum logic [1:0] {M_DBAR = 2'd0, M_TOGGLE = 2'd1, M_PIN = 2'd2, M_PIN_ALT = 2'd3} mode_e;
  typedef enum logic [1:0] {PH_A, PH_B, PH_C, PH_D} phase_e;
  typedef enum logic [1:0] {V_PASS, V_FAIL, V_AGAIN, V_STEP} verdict_e;

  localparam int BIT_DONE = 7;
  localparam int BIT_TOG  = 6;
  localparam int BIT_TMO  = 5;
  localparam logic [7:0] RESET_CMD = 8'hF0;

  function automatic logic dbar_ok(input logic [7:0] d, input logic exp7);
    return d[BIT_DONE] == exp7;
  endfunction

  function automatic logic tog_moved(input logic a, input logic b);
    return a ^ b;
  endfunction

  function automatic logic is_pin_mode(input logic [1:0] m);
    return m[1];
  endfunction
endpackage

// File: rtl/fpoll_eval.sv
module fpoll_eval
  import fpoll_pkg::*;
(
  input  logic [1:0] mode_i,
  input  phase_e     phase_i,
  input  logic [7:0] data_i,
  input  logic       exp7_i,
  input  logic       prev_tog_i,
  output verdict_e   verdict_o,
  output phase_e     phase_nxt_o
);
  logic match, moved, tmo;

  assign match = dbar_ok(data_i, exp7_i);
  assign moved = tog_moved(prev_tog_i, data_i[BIT_TOG]);
  assign tmo   = data_i[BIT_TMO];

  always_comb begin
    verdict_o   = V_STEP;
    phase_nxt_o = phase_i;
    if (mode_i == M_TOGGLE) begin
      case (phase_i)
        PH_A: begin verdict_o = V_STEP; phase_nxt_o = PH_B; end
        PH_B: begin
          if (!moved)   verdict_o = V_PASS;
          else if (tmo) begin verdict_o = V_STEP; phase_nxt_o = PH_C; end
          else          begin verdict_o = V_AGAIN; phase_nxt_o = PH_A; end
        end
        PH_C: begin verdict_o = V_STEP; phase_nxt_o = PH_D; end
        default: verdict_o = moved ? V_FAIL : V_PASS;
      endcase
    end else begin
      if (phase_i == PH_A) begin
        if (match)    verdict_o = V_PASS;
        else if (tmo) begin verdict_o = V_STEP; phase_nxt_o = PH_C; end
        else          verdict_o = V_AGAIN;
      end else begin
        verdict_o = match ? V_PASS : V_FAIL;
      end
    end
  end
endmodule

// File: rtl/fpoll_budget.sv
module fpoll_budget #(
  parameter int MAX_POLLS = 1024,
  localparam int CW = $clog2(MAX_POLLS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          inc_i,
  output logic [CW-1:0] count_o,
  output logic          last_o
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                cnt <= '0;
    else if (clr_i)                            cnt <= '0;
    else if (inc_i && cnt != CW'(MAX_POLLS))   cnt <= cnt + 1'b1;
  end

  assign count_o = cnt;
  assign last_o  = (cnt == CW'(MAX_POLLS - 1));
endmodule

// File: rtl/flash_done_poller.sv
module flash_done_poller
  import fpoll_pkg::*;
#(
  parameter int AW = 22,
  parameter int DW = 16,
  parameter int MAX_POLLS = 1024,
  localparam int CW = $clog2(MAX_POLLS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [AW-1:0] start_addr_i,
  input  logic [DW-1:0] start_data_i,
  input  logic [1:0]    start_mode_i,
  input  logic          rdy_busy_i,
  output logic          bus_req_valid_o,
  input  logic          bus_req_ready_i,
  output logic          bus_req_write_o,
  output logic [AW-1:0] bus_req_addr_o,
  output logic [DW-1:0] bus_req_wdata_o,
  input  logic          bus_rsp_valid_i,
  input  logic [DW-1:0] bus_rsp_data_i,
  output logic          done_o,
  output logic          pass_o,
  output logic          fail_o,
  output logic          busy_o
);
  typedef enum logic [2:0] {S_IDLE, S_REQ, S_RSP, S_PIN, S_RSTWR, S_DONE} state_e;

  state_e        st;
  logic [AW-1:0] addr_q;
  logic          exp7_q, tog_q, pass_q, fail_q;
  logic [1:0]    mode_q;
  phase_e        ph_q, ph_nxt;
  verdict_e      verdict;

  // named events
  logic start_take, rd_fire, wr_fire, rsp_take, budget_inc, budget_last, give_up;
  logic [CW-1:0] poll_count;

  assign start_take = (st == S_IDLE) && start_i;
  assign rd_fire    = (st == S_REQ) && bus_req_ready_i;
  assign wr_fire    = (st == S_RSTWR) && bus_req_ready_i;
  assign rsp_take   = (st == S_RSP) && bus_rsp_valid_i;
  assign budget_inc = (rsp_take && verdict == V_AGAIN) || ((st == S_PIN) && !rdy_busy_i);
  assign give_up    = budget_inc && budget_last;

  fpoll_eval u_eval (
    .mode_i      (mode_q),
    .phase_i     (ph_q),
    .data_i      (bus_rsp_data_i[7:0]),
    .exp7_i      (exp7_q),
    .prev_tog_i  (tog_q),
    .verdict_o   (verdict),
    .phase_nxt_o (ph_nxt)
  );

  fpoll_budget #(.MAX_POLLS(MAX_POLLS)) u_budget (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_i   (start_take),
    .inc_i   (budget_inc),
    .count_o (poll_count),
    .last_o  (budget_last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      addr_q <= '0;
      exp7_q <= 1'b0;
      mode_q <= 2'd0;
      ph_q   <= PH_A;
      tog_q  <= 1'b0;
      pass_q <= 1'b0;
      fail_q <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (start_i) begin
          addr_q <= start_addr_i;
          exp7_q <= start_data_i[BIT_DONE];
          mode_q <= start_mode_i;
          ph_q   <= PH_A;
          pass_q <= 1'b0;
          fail_q <= 1'b0;
          st     <= is_pin_mode(start_mode_i) ? S_PIN : S_REQ;
        end
        S_REQ: if (rd_fire) st <= S_RSP;
        S_RSP: if (bus_rsp_valid_i) begin
          tog_q <= bus_rsp_data_i[BIT_TOG];
          ph_q  <= ph_nxt;
          case (verdict)
            V_PASS:  begin pass_q <= 1'b1; st <= S_DONE; end
            V_FAIL:  st <= S_RSTWR;
            V_AGAIN: st <= give_up ? S_RSTWR : S_REQ;
            default: st <= S_REQ;
          endcase
        end
        S_PIN: begin
          if (rdy_busy_i)   begin pass_q <= 1'b1; st <= S_DONE; end
          else if (give_up) st <= S_RSTWR;
        end
        S_RSTWR: if (wr_fire) begin fail_q <= 1'b1; st <= S_DONE; end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign bus_req_valid_o = (st == S_REQ) || (st == S_RSTWR);
  assign bus_req_write_o = (st == S_RSTWR);
  assign bus_req_addr_o  = addr_q;
  assign bus_req_wdata_o = (st == S_RSTWR) ? DW'(RESET_CMD) : '0;
  assign done_o = (st == S_DONE);
  assign pass_o = pass_q;
  assign fail_o = fail_q;
  assign busy_o = (st != S_IDLE);
endmodule

// File: rtl/fpoll_chk.sv
module fpoll_chk #(
  parameter int AW = 22,
  parameter int DW = 16,
  parameter int MAX_POLLS = 1024,
  localparam int CW = $clog2(MAX_POLLS + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start_i,
  input logic          bus_req_valid_o,
  input logic          bus_req_ready_i,
  input logic          bus_req_write_o,
  input logic [AW-1:0] bus_req_addr_o,
  input logic [DW-1:0] bus_req_wdata_o,
  input logic          done_o,
  input logic          pass_o,
  input logic          fail_o,
  input logic          busy_o,
  input logic          wr_fire,
  input logic [CW-1:0] poll_count
);
  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req_valid_o && !bus_req_ready_i |=> bus_req_valid_o && $stable(bus_req_addr_o)
      && $stable(bus_req_write_o) && $stable(bus_req_wdata_o));
  // R8
  done_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $countones({pass_o, fail_o}) == 1);
  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  // R8
  fail_after_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && fail_o |-> $past(wr_fire));
  // R8
  wr_then_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |=> done_o && fail_o);
  // R9
  budget_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    poll_count <= CW'(MAX_POLLS));
  // R11
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && start_i |=> $stable(bus_req_addr_o));
  // R10
  req_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req_valid_o |-> busy_o);
endmodule

bind flash_done_poller fpoll_chk #(.AW(AW), .DW(DW), .MAX_POLLS(MAX_POLLS)) chk_i (
  .clk(clk), .rst_n(rst_n), .start_i(start_i),
  .bus_req_valid_o(bus_req_valid_o), .bus_req_ready_i(bus_req_ready_i),
  .bus_req_write_o(bus_req_write_o), .bus_req_addr_o(bus_req_addr_o),
  .bus_req_wdata_o(bus_req_wdata_o), .done_o(done_o), .pass_o(pass_o),
  .fail_o(fail_o), .busy_o(busy_o), .wr_fire(wr_fire), .poll_count(poll_count)
);

// File: tb/flash_done_poller_tb_top.sv
module flash_done_poller_tb_top;
  localparam int AW = 22;
  localparam int DW = 16;
  localparam int MAXP = 8;

  logic clk = 0, rst_n = 0;
  logic start = 0;
  logic [AW-1:0] s_addr = '0;
  logic [DW-1:0] s_data = '0;
  logic [1:0] s_mode = '0;
  logic rdy = 0;
  logic req_valid, req_write, rsp_valid = 0;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_wdata, rsp_data = '0;
  logic done, pass, fail, busy;
  logic stall_en = 0, tick = 0, clr_req = 0;
  logic req_ready;

  logic [DW-1:0] script [16];
  int rd_cnt = 0, wr_cnt = 0, idx = 0;
  logic [DW-1:0] wr_data = '0;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0;
  logic rd_addr_bad = 0;

  int total = 0, bad = 0, cyc = 0;

  always #2 clk = ~clk;

  assign req_ready = !stall_en || tick;

  flash_done_poller #(.AW(AW), .DW(DW), .MAX_POLLS(MAXP)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start), .start_addr_i(s_addr),
    .start_data_i(s_data), .start_mode_i(s_mode), .rdy_busy_i(rdy),
    .bus_req_valid_o(req_valid), .bus_req_ready_i(req_ready),
    .bus_req_write_o(req_write), .bus_req_addr_o(req_addr),
    .bus_req_wdata_o(req_wdata), .bus_rsp_valid_i(rsp_valid),
    .bus_rsp_data_i(rsp_data), .done_o(done), .pass_o(pass),
    .fail_o(fail), .busy_o(busy)
  );

  // bus model: one response the cycle after an accepted read
  always @(posedge clk) begin
    tick <= ~tick;
    rsp_valid <= 1'b0;
    if (clr_req) begin
      rd_cnt <= 0; wr_cnt <= 0; idx <= 0; rd_addr_bad <= 1'b0;
    end else if (req_valid && req_ready) begin
      if (req_write) begin
        wr_cnt <= wr_cnt + 1; wr_data <= req_wdata; wr_addr <= req_addr;
      end else begin
        rsp_valid <= 1'b1;
        rsp_data <= script[idx];
        if (idx < 15) idx <= idx + 1;
        rd_cnt <= rd_cnt + 1;
        if (rd_cnt > 0 && req_addr != rd_addr) rd_addr_bad <= 1'b1;
        rd_addr <= req_addr;
      end
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      bad = bad + 1;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("  test done: total=%0d bad=%0d", total + 1, bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic set_script(input logic [DW-1:0] a, b, c, d);
    script[0] = a; script[1] = b; script[2] = c;
    for (int i = 3; i < 16; i++) script[i] = d;
    clr_req = 1; @(negedge clk); clr_req = 0;
  endtask

  task automatic do_start(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [1:0] m);
    s_addr = a; s_data = d; s_mode = m; start = 1;
    @(negedge clk);
    start = 0;
  endtask

  task automatic wait_done(input string tag);
    int n = 0;
    while (!done && n < 400) begin @(negedge clk); n++; end
    chk(done, tag, done, 1);
  endtask

  task automatic expect_result(input string tag, input bit exp_pass, input int exp_rd,
                               input int exp_wr, input logic [AW-1:0] a);
    chk(pass == exp_pass && fail == !exp_pass, {tag, " result"}, {pass, fail}, {exp_pass, !exp_pass});
    chk(rd_cnt == exp_rd, {tag, " reads"}, rd_cnt, exp_rd);
    chk(wr_cnt == exp_wr, {tag, " writes"}, wr_cnt, exp_wr);
    if (exp_wr != 0) begin
      chk(wr_data == 16'h00F0, {tag, " R8 wdata"}, wr_data, 16'h00F0);
      chk(wr_addr == a, {tag, " R8 waddr"}, wr_addr, a);
    end
    if (exp_rd > 0) chk(rd_addr == a && !rd_addr_bad, {tag, " R2 raddr"}, rd_addr, a);
    @(negedge clk);
    chk(!done && !busy, {tag, " R8 pulse"}, done, 0);
    chk(pass == exp_pass && fail == !exp_pass, {tag, " R8 hold"}, pass, exp_pass);
  endtask

  task automatic t_reset;
    chk(!done && !pass && !fail && !busy && !req_valid, "R1 reset", {done, pass, fail, busy, req_valid}, 0);
  endtask

  task automatic t_dbar_quick;
    set_script(16'h0080, 16'h0080, 16'h0080, 16'h0080);
    do_start(22'h12345, 16'h00FF, 2'd0); wait_done("R2 quick");
    expect_result("R2 quick", 1, 1, 0, 22'h12345);
  endtask

  task automatic t_dbar_again;
    set_script(16'h0000, 16'h0000, 16'h0080, 16'h0080);
    do_start(22'h00AAA, 16'h00A5, 2'd0); wait_done("R3 again");
    expect_result("R3 again", 1, 3, 0, 22'h00AAA);
  endtask

  task automatic t_dbar_recheck_pass;
    set_script(16'h0020, 16'h0080, 16'h0000, 16'h0000);
    do_start(22'h00100, 16'h0080, 2'd0); wait_done("R4 recheck pass");
    expect_result("R4 recheck pass", 1, 2, 0, 22'h00100);
  endtask

  task automatic t_dbar_recheck_fail;
    set_script(16'h0020, 16'h0020, 16'h0080, 16'h0080);
    do_start(22'h3F00F, 16'h0080, 2'd0); wait_done("R4 recheck fail");
    expect_result("R4 recheck fail", 0, 2, 1, 22'h3F00F);
  endtask

  task automatic t_tog_pair;
    set_script(16'h0000, 16'h0040, 16'h0040, 16'h0040);
    do_start(22'h00200, 16'h0000, 2'd1); wait_done("R5 toggle");
    expect_result("R5 toggle", 1, 4, 0, 22'h00200);
  endtask

  task automatic t_tog_recheck_pass;
    set_script(16'h0000, 16'h0060, 16'h0040, 16'h0040);
    do_start(22'h00300, 16'h0000, 2'd1); wait_done("R6 toggle pass");
    expect_result("R6 toggle pass", 1, 4, 0, 22'h00300);
  endtask

  task automatic t_tog_recheck_fail;
    set_script(16'h0000, 16'h0060, 16'h0040, 16'h0000);
    do_start(22'h00400, 16'h0000, 2'd1); wait_done("R6 toggle fail");
    expect_result("R6 toggle fail", 0, 4, 1, 22'h00400);
  endtask

  task automatic t_pin;
    set_script(16'h0000, 16'h0000, 16'h0000, 16'h0000);
    rdy = 0;
    do_start(22'h00500, 16'h0000, 2'd2);
    repeat (4) @(negedge clk);
    chk(busy && !done, "R7 pin wait", busy, 1);
    rdy = 1; wait_done("R7 pin");
    expect_result("R7 pin", 1, 0, 0, 22'h00500);
    rdy = 0;
  endtask

  task automatic t_budget_dbar;
    set_script(16'h0000, 16'h0000, 16'h0000, 16'h0000);
    do_start(22'h00600, 16'h0080, 2'd0); wait_done("R9 budget");
    expect_result("R9 budget", 0, MAXP, 1, 22'h00600);
  endtask

  task automatic t_budget_pin;
    set_script(16'h0000, 16'h0000, 16'h0000, 16'h0000);
    rdy = 0;
    do_start(22'h00700, 16'h0000, 2'd3); wait_done("R9 pin budget");
    expect_result("R9 pin budget", 0, 0, 1, 22'h00700);
  endtask

  task automatic t_busy_start;
    stall_en = 1;
    set_script(16'h0000, 16'h0000, 16'h0080, 16'h0080);
    do_start(22'h00800, 16'h0080, 2'd0);
    repeat (2) @(negedge clk);
    rdy = 1;
    do_start(22'h00999, 16'h0000, 2'd2);
    wait_done("R11 busy start");
    expect_result("R11 R10 busy start stalled", 1, 3, 0, 22'h00800);
    rdy = 0; stall_en = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_dbar_quick();
    t_dbar_again();
    t_dbar_recheck_pass();
    t_dbar_recheck_fail();
    t_tog_pair();
    t_tog_recheck_pass();
    t_tog_recheck_fail();
    t_pin();
    t_budget_dbar();
    t_budget_pin();
    t_busy_start();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule